// File: doc/BRIEF.md
# Header-word FIFO fetch controller

This block sits between an external synchronous FIFO and the outbound channel of a connection-oriented link. When the host asks for a connection and the FIFO reports data, the block pulls the FIFO's active-low read enable low. It keeps reading until the word sitting in the FIFO output register carries the header tag: packet-available clear and short-burst set. The read enable is released in the same cycle that tag appears, without waiting for a clock edge, so the header word stays frozen in the FIFO output register.

The FIFO word always flows through a two-register pipeline toward the channel. A marker travels alongside the header word in that pipeline. The channel request is raised exactly when the header reaches the channel data outputs, two clock edges after the match cycle. From then on the block issues no FIFO reads. When the connection outcome (accept or reject) is reported, it raises a release flag that hands read control to the downstream burst logic. Dropping the host request returns the block to idle from any state.

The channel side is a plain level interface and has no back-pressure. The header word is held static by the frozen FIFO register, and the request stays up until the host withdraws it.

Top module: `hdr_fetch_ctrl`

## Requirements
- R1: In idle, with `host_req` and `fifo_not_empty` both high at a clock edge, `fifo_rd_n` is low in the following cycle. While `fifo_not_empty` is low, no fetch starts and `fifo_rd_n` stays high.
- R2: In the first cycle of a fetch, `fifo_rd_n` is low whatever the tag bits show, so at least one FIFO word is always read.
- R3: From the second fetch cycle onward, `fifo_rd_n` goes high in the same cycle that the tags read `fifo_pkt_tag`=0 and `fifo_short_tag`=1, and `pipe_ld` is high in that cycle only. For any other tag value, `fifo_rd_n` stays low.
- R4: `chan_req` rises at the second clock edge after the match cycle of R3. It is not high at the first edge.
- R5: `chan_data` is the FIFO output word delayed by two clock registers, so it equals the header word from the cycle `chan_req` rises.
- R6: After the match and until the host request drops, `fifo_rd_n` stays high and the FIFO output word does not change.
- R7: While `chan_req` is high, `conn_resolved` high at a clock edge makes `rd_release` high from the next cycle until the host request drops.
- R8: When `host_req` is low at a clock edge, the next cycle has `fifo_rd_n` high and `chan_req` and `rd_release` low, and the block is idle. A drop during a fetch means `chan_req` never rises for that fetch.
- R9: After reset, `fifo_rd_n` is high and `pipe_ld`, `chan_req` and `rd_release` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host connection request level |
| fifo_not_empty | input | 1 | FIFO holds at least one word |
| fifo_pkt_tag | input | 1 | Packet-available tag of the FIFO output word |
| fifo_short_tag | input | 1 | Short-burst tag of the FIFO output word |
| fifo_word | input | W | FIFO output register data |
| conn_resolved | input | 1 | Connection accepted or rejected |
| fifo_rd_n | output | 1 | Active-low FIFO read enable |
| pipe_ld | output | 1 | Header enters the output pipeline this cycle |
| chan_data | output | W | Channel data, two registers behind the FIFO |
| chan_req | output | 1 | Channel connection request |
| rd_release | output | 1 | Header phase finished; burst logic may read |

## Verification
The read enable reacts one edge after the start condition. It then reacts within the same cycle to the header tag, with no edge in between. The request and the header data on the channel follow two edges after the match, and the release flag and the idle return each follow one edge after their cause. The bench drives inputs on the falling edge and samples on the next falling edge, so each sample sees exactly the edges counted above. It also checks that the request is still low one edge after the match. Random trials vary the filler-word count ahead of the header, the stale tag left in the FIFO register and the resolution delay, and a model FIFO in the bench advances only on a low read enable.

// File: rtl/hdr_fetch_pkg.sv
`timescale 1ns/1ps
package hdr_fetch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_HOLD,
    ST_REQ,
    ST_REL
  } fetch_st_e;

  localparam int unsigned HDR_PKT_VAL   = 0;
  localparam int unsigned HDR_SHORT_VAL = 1;
endpackage

// File: rtl/hdr_tag_decode.sv
`timescale 1ns/1ps
module hdr_tag_decode #(
  parameter bit PKT_VAL   = 1'b0,
  parameter bit SHORT_VAL = 1'b1
) (
  input  logic pkt_tag,
  input  logic short_tag,
  output logic hit
);
  // purely combinational so the release of the read enable needs no edge
  assign hit = (pkt_tag == PKT_VAL) && (short_tag == SHORT_VAL);
endmodule

// File: rtl/hdr_out_pipe.sv
`timescale 1ns/1ps
module hdr_out_pipe #(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     din,
  input  logic             mark_in,
  output logic [W-1:0]     dout,
  output logic [DEPTH-1:0] mark_vec
);
  logic [W-1:0] stage_q [DEPTH];
  logic [DEPTH-1:0] mark_q;

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            stage_q[s] <= '0;
            mark_q[s]  <= 1'b0;
          end else begin
            stage_q[s] <= din;
            mark_q[s]  <= mark_in;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            stage_q[s] <= '0;
            mark_q[s]  <= 1'b0;
          end else begin
            stage_q[s] <= stage_q[s-1];
            mark_q[s]  <= mark_q[s-1];
          end
        end
      end
    end
  endgenerate

  assign dout     = stage_q[DEPTH-1];
  assign mark_vec = mark_q;
endmodule

// File: rtl/hdr_fetch_fsm.sv
`timescale 1ns/1ps
module hdr_fetch_fsm
  import hdr_fetch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic host_req,
  input  logic fifo_not_empty,
  input  logic tag_hit,
  input  logic conn_resolved,
  input  logic hdr_near,
  output logic fifo_rd_n,
  output logic pipe_ld,
  output logic chan_req,
  output logic rd_release
);
  fetch_st_e state_q;
  logic rd_en_q, armed_q, req_q;
  logic match;

  // tags are ignored in the first fetch cycle: the register may hold a stale word
  assign match = (state_q == ST_FETCH) && armed_q && tag_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rd_en_q <= 1'b0;
      armed_q <= 1'b0;
      req_q   <= 1'b0;
    end else if (!host_req) begin
      state_q <= ST_IDLE;
      rd_en_q <= 1'b0;
      armed_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (fifo_not_empty) begin
            state_q <= ST_FETCH;
            rd_en_q <= 1'b1;
            armed_q <= 1'b0;
          end
        end
        ST_FETCH: begin
          armed_q <= 1'b1;
          if (match) begin
            state_q <= ST_HOLD;
            rd_en_q <= 1'b0;
            armed_q <= 1'b0;
          end
        end
        ST_HOLD: begin
          if (hdr_near) begin
            req_q   <= 1'b1;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (conn_resolved) state_q <= ST_REL;
        end
        ST_REL: state_q <= ST_REL;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fifo_rd_n  = !rd_en_q || match;
  assign pipe_ld    = match;
  assign chan_req   = req_q;
  assign rd_release = (state_q == ST_REL);

  // R2
  first_cycle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en_q) |-> !fifo_rd_n);
  // R6
  no_read_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {ST_HOLD, ST_REQ, ST_REL}) |-> fifo_rd_n);
  // R8
  drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_req |=> (fifo_rd_n && !chan_req && !rd_release));
  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_req && conn_resolved && host_req) |=> rd_release);
endmodule

// File: rtl/hdr_fetch_ctrl.sv
`timescale 1ns/1ps
module hdr_fetch_ctrl #(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_req,
  input  logic         fifo_not_empty,
  input  logic         fifo_pkt_tag,
  input  logic         fifo_short_tag,
  input  logic [W-1:0] fifo_word,
  input  logic         conn_resolved,
  output logic         fifo_rd_n,
  output logic         pipe_ld,
  output logic [W-1:0] chan_data,
  output logic         chan_req,
  output logic         rd_release
);
  localparam int NEAR_IDX = DEPTH - 2;

  logic tag_hit;
  logic [DEPTH-1:0] mark_vec;

  hdr_tag_decode #(
    .PKT_VAL   (1'(hdr_fetch_pkg::HDR_PKT_VAL)),
    .SHORT_VAL (1'(hdr_fetch_pkg::HDR_SHORT_VAL))
  ) u_dec (
    .pkt_tag   (fifo_pkt_tag),
    .short_tag (fifo_short_tag),
    .hit       (tag_hit)
  );

  hdr_out_pipe #(.W(W), .DEPTH(DEPTH)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (fifo_word),
    .mark_in  (pipe_ld),
    .dout     (chan_data),
    .mark_vec (mark_vec)
  );

  hdr_fetch_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_req       (host_req),
    .fifo_not_empty (fifo_not_empty),
    .tag_hit        (tag_hit),
    .conn_resolved  (conn_resolved),
    .hdr_near       (mark_vec[NEAR_IDX]),
    .fifo_rd_n      (fifo_rd_n),
    .pipe_ld        (pipe_ld),
    .chan_req       (chan_req),
    .rd_release     (rd_release)
  );

  // R4
  req_at_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_req) |-> mark_vec[DEPTH-1]);
  // R3
  match_frees_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_ld |-> (fifo_rd_n && tag_hit));
endmodule

// File: tb/hdr_fetch_ctrl_bench.sv
`timescale 1ns/1ps
module hdr_fetch_ctrl_bench;
  localparam int CLK_PERIOD = 40;
  localparam int W = 32;
  localparam int WDOG = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, host_req, fifo_not_empty, conn_resolved;
  logic fifo_rd_n, pipe_ld, chan_req, rd_release;
  logic [W-1:0] chan_data;

  // bench FIFO model: output register advances on a low read enable
  logic [W-1:0] mem_w [16];
  logic [1:0]   mem_t [16];
  logic [3:0]   rd_ptr;
  logic [W-1:0] out_w;
  logic [1:0]   out_t;   // {pkt, short}

  always @(posedge clk) begin
    if (!fifo_rd_n && fifo_not_empty) begin
      out_w  <= mem_w[rd_ptr];
      out_t  <= mem_t[rd_ptr];
      rd_ptr <= rd_ptr + 4'd1;
    end
  end

  hdr_fetch_ctrl #(.W(W), .DEPTH(2)) u_hdr_fetch_ctrl (
    .clk(clk), .rst_n(rst_n), .host_req(host_req),
    .fifo_not_empty(fifo_not_empty),
    .fifo_pkt_tag(out_t[1]), .fifo_short_tag(out_t[0]),
    .fifo_word(out_w), .conn_resolved(conn_resolved),
    .fifo_rd_n(fifo_rd_n), .pipe_ld(pipe_ld), .chan_data(chan_data),
    .chan_req(chan_req), .rd_release(rd_release)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [1:0] filler_tag(input int unsigned r);
    case (r % 3)
      0: return 2'b00;
      1: return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      finish_run();
    end
  end

  // load FIFO: k fillers, then header at index k; stale word in output register
  task automatic load_fifo(input int k, input logic [1:0] stale, output logic [W-1:0] hdr);
    for (int i = 0; i < 16; i++) begin
      mem_w[i] = $urandom;
      mem_t[i] = filler_tag($urandom);
    end
    mem_t[k] = 2'b01;
    hdr = mem_w[k];
    out_w = $urandom;
    out_t = stale;
    rd_ptr = 4'd0;
  endtask

  task automatic run_trial(input int k, input logic [1:0] stale, input int d);
    logic [W-1:0] hdr;
    load_fifo(k, stale, hdr);
    host_req = 1'b1; fifo_not_empty = 1'b1;
    @(negedge clk);
    chk(fifo_rd_n == 1'b0, "R1 fetch starts", W'(fifo_rd_n), 0);
    chk(pipe_ld == 1'b0, "R2 stale tag ignored", W'(pipe_ld), 0);
    for (int i = 0; i <= k; i++) begin
      @(negedge clk);
      if (i < k) begin
        chk(fifo_rd_n == 1'b0, "R3 filler keeps reading", W'(fifo_rd_n), 0);
      end else begin
        chk(fifo_rd_n == 1'b1, "R3 same-cycle release", W'(fifo_rd_n), 1);
        chk(pipe_ld == 1'b1, "R3 pipe_ld on match", W'(pipe_ld), 1);
      end
    end
    @(negedge clk);
    chk(chan_req == 1'b0, "R4 not early", W'(chan_req), 0);
    chk(pipe_ld == 1'b0, "R3 pipe_ld single", W'(pipe_ld), 0);
    @(negedge clk);
    chk(chan_req == 1'b1, "R4 request on time", W'(chan_req), 1);
    chk(chan_data == hdr, "R5 header on channel", chan_data, hdr);
    for (int j = 0; j < d; j++) begin
      chk(fifo_rd_n == 1'b1 && out_w == hdr, "R6 no read while waiting", out_w, hdr);
      chk(rd_release == 1'b0, "R7 no early release", W'(rd_release), 0);
      @(negedge clk);
    end
    chk(chan_data == hdr, "R5 header held", chan_data, hdr);
    conn_resolved = 1'b1;
    @(negedge clk);
    conn_resolved = 1'b0;
    chk(rd_release == 1'b1, "R7 release", W'(rd_release), 1);
    @(negedge clk);
    chk(rd_release == 1'b1 && chan_req == 1'b1, "R7 release held", W'(rd_release), 1);
    host_req = 1'b0;
    @(negedge clk);
    chk(fifo_rd_n == 1'b1 && !chan_req && !rd_release, "R8 idle after drop",
        W'({fifo_rd_n, chan_req, rd_release}), W'(3'b100));
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; host_req = 1'b0; fifo_not_empty = 1'b0; conn_resolved = 1'b0;
    rd_ptr = 4'd0; out_w = '0; out_t = 2'b00;
    repeat (3) @(negedge clk);
    chk(fifo_rd_n == 1'b1, "R9 reset rd_n", W'(fifo_rd_n), 1);
    chk(!pipe_ld && !chan_req && !rd_release, "R9 reset outputs",
        W'({pipe_ld, chan_req, rd_release}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty FIFO never starts a fetch
    host_req = 1'b1; fifo_not_empty = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(fifo_rd_n == 1'b1, "R1 empty blocks fetch", W'(fifo_rd_n), 1);
    end
    host_req = 1'b0;
    @(negedge clk);

    // directed corners: header first with stale header tag (R2), deeper header
    run_trial(0, 2'b01, 2);
    run_trial(3, 2'b00, 0);
    run_trial(7, 2'b11, 5);

    // R8: drop in the middle of a fetch
    begin
      logic [W-1:0] hdr;
      load_fifo(5, 2'b10, hdr);
      host_req = 1'b1; fifo_not_empty = 1'b1;
      @(negedge clk);
      @(negedge clk);
      host_req = 1'b0;
      @(negedge clk);
      chk(fifo_rd_n == 1'b1, "R8 drop stops read", W'(fifo_rd_n), 1);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(chan_req == 1'b0, "R8 request suppressed", W'(chan_req), 0);
      end
    end

    for (int t = 0; t < 20; t++) begin
      run_trial(int'($urandom_range(0, 8)), 2'($urandom_range(0, 3)),
                int'($urandom_range(0, 6)));
    end
    finish_run();
  end
endmodule